// File: doc/BRIEF.md
# Texture-mapper control register bank

This block is the software-facing register bank of a mesh-based texture-mapping engine. A processor programs nineteen 32-bit configuration words through a simple word-access port. Those words describe the mesh extent, the source texture, the destination surface, the blend levels and a chroma-key enable. The bank hands all configuration words to the engine as one flat vector. A job is launched by writing the control word with its go bit set.

While the engine works, the go bit reads back as busy and the configuration is frozen. When the engine reports completion, the bank drops busy and raises a one-cycle interrupt. Every accepted write is screened for out-of-range blend levels and misaligned buffer addresses. Every access is screened for an unmapped offset or a size other than a full word. Each problem found sets a sticky flag in a read-only status word, and software clears a flag by writing 1 to its bit.

Top module: `texmap_csr_bank`

## Requirements
- R1: After reset, every configuration word, the status word, busy, eng_start and irq are all zero.
- R2: The word index is req_addr shifted right by 2. Indices 0 to 18 are configuration words with these roles: 0 control, 1 and 2 mesh column/row last, 3 brightness, 4 chroma key value, 5 vertex table address, 6 texture base, 7/8 texture width/height, 9/10 texture wrap masks, 11 destination base, 12/13 destination width/height, 14/15 destination x/y offset, 16/17 tile width/height, 18 alpha. A full-word write to one of them while idle stores all 32 bits. That word then appears at bits [32*i+31:32*i] of cfg_flat. A read returns the word on rd_data, with rd_valid high, one cycle after the request.
- R3: Control bit 1 (chroma-key enable) is stored as written. Writing the control word with bit 0 set while idle sets busy and raises eng_start for exactly one cycle. Control bit 0 reads back as busy.
- R4: eng_done sampled while busy clears busy (control bit 0) and produces a single-cycle irq pulse in the next cycle. eng_done while idle has no effect.
- R5: While busy, writes to any configuration word, including the control word, are ignored, and no second eng_start is issued.
- R6: An accepted write of a value above 63 to brightness (index 3) sets status bit 0. The same to alpha (index 18) sets status bit 1. A value of 63 or less sets nothing. The value is stored either way.
- R7: An accepted write to the vertex table address (index 5) with any of bits [2:0] set sets status bit 2. An accepted write to the texture base (index 6) with bit 0 set sets status bit 3.
- R8: A full-word access at index 20 or above reads as zero, changes no register, and sets status bit 4.
- R9: An access whose req_bytes is not 4 is ignored on write, reads as zero, and sets status bit 5.
- R10: The status word sits at index 19 and is read-only. A write there clears each flag whose data bit is 1 and leaves flags whose data bit is 0. Flags never clear by themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_bytes | input | 3 | Access size in bytes (only 4 is legal) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| cfg_flat | output | 608 | All configuration words, word i at bits [32*i+31:32*i] |
| busy | output | 1 | Engine job in progress |
| eng_start | output | 1 | One-cycle launch strobe to the engine |
| eng_done | input | 1 | Completion strobe from the engine |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The register map is filled with a per-index pattern that makes each word distinct, then read back. This shows that no two indices alias and that the address shift is right. The legality checks are driven with values on both sides of each limit: 63 against 64 for the blend levels, and an address with only bit 2 set against one with bit 3 set for the vertex table. These separate an off-by-one limit or a wrong mask from a correct one. Illegal accesses are followed by reads of the word they would have hit, so a dropped write can be told from a stored one. A write issued mid-job, with the control word reread before and after completion, separates the busy freeze from plain storage.

// File: rtl/texmap_csr_pkg.sv
package texmap_csr_pkg;
   // configuration word roles whose index the legality logic depends on
   localparam int unsigned IDX_CTL     = 0;
   localparam int unsigned IDX_BRIGHT  = 3;
   localparam int unsigned IDX_VTXADDR = 5;
   localparam int unsigned IDX_TEXBASE = 6;
   localparam int unsigned IDX_ALPHA   = 18;

   // status flag positions
   localparam int unsigned ERR_BRIGHT = 0;
   localparam int unsigned ERR_ALPHA  = 1;
   localparam int unsigned ERR_VTX    = 2;
   localparam int unsigned ERR_TEX    = 3;
   localparam int unsigned ERR_RANGE  = 4;
   localparam int unsigned ERR_SIZE   = 5;
   localparam int unsigned ERR_W      = 6;

   localparam int unsigned CTL_GO_BIT = 0;
endpackage

// File: rtl/texmap_csr_decode.sv
module texmap_csr_decode #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned NUM_CFG    = 19,
   parameter int unsigned WORD_BYTES = 4,
   localparam int unsigned SHIFT     = $clog2(WORD_BYTES),
   localparam int unsigned IDX_W     = ADDR_W - SHIFT
) (
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_bytes,
   output logic [IDX_W-1:0]  idx,
   output logic              cfg_hit,
   output logic              stat_hit,
   output logic              range_err,
   output logic              size_err
);
   generate
      if ((2 ** IDX_W) <= NUM_CFG) begin : g_bad_addr_w
         $error("address width too small for register map");
      end
   endgenerate

   logic size_ok;

   always_comb begin
      idx       = req_addr[ADDR_W-1:SHIFT];
      size_ok   = (req_bytes == 3'(WORD_BYTES));
      cfg_hit   = req_valid && size_ok && (idx <  IDX_W'(NUM_CFG));
      stat_hit  = req_valid && size_ok && (idx == IDX_W'(NUM_CFG));
      range_err = req_valid && size_ok && (idx >  IDX_W'(NUM_CFG));
      size_err  = req_valid && !size_ok;
   end
endmodule

// File: rtl/texmap_csr_regfile.sv
module texmap_csr_regfile #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_CFG = 19,
   parameter int unsigned IDX_W   = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            busy,
   input  logic                            we,
   input  logic [IDX_W-1:0]                idx,
   input  logic [DATA_W-1:0]               wdata,
   output logic [NUM_CFG-1:0][DATA_W-1:0]  words
);
   import texmap_csr_pkg::*;

   generate
      for (genvar i = 0; i < NUM_CFG; i++) begin : g_word
         if (i == IDX_CTL) begin : g_ctl
            // go bit is owned by the job controller; storage keeps it zero
            always_ff @(posedge clk) begin
               if (!rst_n)
                  words[i] <= '0;
               else if (we && idx == IDX_W'(i))
                  words[i] <= wdata & ~(DATA_W'(1) << CTL_GO_BIT);
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (!rst_n)
                  words[i] <= '0;
               else if (we && idx == IDX_W'(i))
                  words[i] <= wdata;
            end
         end
      end
   endgenerate

   // R5: configuration frozen across a running job
   p_frozen_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(words));
endmodule

// File: rtl/texmap_csr_check.sv
module texmap_csr_check #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned LEVEL_MAX = 63
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic                            stat_we,
   input  logic [IDX_W-1:0]                idx,
   input  logic [DATA_W-1:0]               wdata,
   input  logic                            range_err,
   input  logic                            size_err,
   output logic [texmap_csr_pkg::ERR_W-1:0] status
);
   import texmap_csr_pkg::*;

   logic [ERR_W-1:0] set_v, clr_v;

   always_comb begin
      set_v = '0;
      set_v[ERR_BRIGHT] = cfg_we && idx == IDX_W'(IDX_BRIGHT) && wdata > DATA_W'(LEVEL_MAX);
      set_v[ERR_ALPHA]  = cfg_we && idx == IDX_W'(IDX_ALPHA)  && wdata > DATA_W'(LEVEL_MAX);
      set_v[ERR_VTX]    = cfg_we && idx == IDX_W'(IDX_VTXADDR) && (wdata[2:0] != 3'd0);
      set_v[ERR_TEX]    = cfg_we && idx == IDX_W'(IDX_TEXBASE) && wdata[0];
      set_v[ERR_RANGE]  = range_err;
      set_v[ERR_SIZE]   = size_err;
      clr_v = stat_we ? wdata[ERR_W-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_v) | set_v;
   end

   // R10: flags only drop on a status write
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_we |=> ((status & $past(status)) == $past(status)));
   // R8: an unmapped access always leaves its flag set
   p_range_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |=> status[ERR_RANGE]);
endmodule

// File: rtl/texmap_csr_job.sv
module texmap_csr_job (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic eng_done,
   output logic busy,
   output logic eng_start,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         eng_start <= 1'b0;
         irq       <= 1'b0;
      end else begin
         eng_start <= 1'b0;
         irq       <= 1'b0;
         if (!busy && go) begin
            busy      <= 1'b1;
            eng_start <= 1'b1;
         end else if (busy && eng_done) begin
            busy <= 1'b0;
            irq  <= 1'b1;
         end
      end
   end

   // R3: launch strobe only on the idle-to-busy step
   p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (busy && !$past(busy)));
   // R4: interrupt is one cycle wide and follows the end of a job
   p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   p_irq_after_job_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy && $past(busy)));
endmodule

// File: rtl/texmap_csr_bank.sv
module texmap_csr_bank #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_CFG   = 19,
   parameter int unsigned LEVEL_MAX = 63,
   localparam int unsigned IDX_W    = ADDR_W - 2,
   localparam int unsigned CFG_W    = NUM_CFG * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_bytes,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [CFG_W-1:0]  cfg_flat,
   output logic              busy,
   output logic              eng_start,
   input  logic              eng_done,
   output logic              irq
);
   import texmap_csr_pkg::*;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("register bank is defined for 32-bit words only");
      end
      if (NUM_CFG <= IDX_ALPHA) begin : g_bad_num_cfg
         $error("register count must cover the alpha word");
      end
   endgenerate

   logic [IDX_W-1:0]               idx;
   logic                           cfg_hit, stat_hit, range_err, size_err;
   logic                           cfg_we, stat_we, go;
   logic [NUM_CFG-1:0][DATA_W-1:0] words;
   logic [ERR_W-1:0]               status;
   logic [DATA_W-1:0]              rd_next;

   texmap_csr_decode #(.ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG), .WORD_BYTES(DATA_W/8)) u_dec (
      .req_valid(req_valid), .req_addr(req_addr), .req_bytes(req_bytes),
      .idx(idx), .cfg_hit(cfg_hit), .stat_hit(stat_hit),
      .range_err(range_err), .size_err(size_err));

   always_comb begin
      cfg_we  = cfg_hit && req_write && !busy;
      stat_we = stat_hit && req_write;
      go      = cfg_we && idx == IDX_W'(IDX_CTL) && req_wdata[CTL_GO_BIT];
   end

   texmap_csr_regfile #(.DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n), .busy(busy), .we(cfg_we), .idx(idx),
      .wdata(req_wdata), .words(words));

   texmap_csr_check #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LEVEL_MAX(LEVEL_MAX)) u_chk (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .stat_we(stat_we), .idx(idx),
      .wdata(req_wdata), .range_err(range_err), .size_err(size_err), .status(status));

   texmap_csr_job u_job (
      .clk(clk), .rst_n(rst_n), .go(go), .eng_done(eng_done),
      .busy(busy), .eng_start(eng_start), .irq(irq));

   assign cfg_flat = words;

   always_comb begin
      rd_next = '0;
      if (cfg_hit) begin
         for (int i = 0; i < NUM_CFG; i++)
            if (idx == IDX_W'(i)) rd_next = words[i];
         if (idx == IDX_W'(IDX_CTL)) rd_next[CTL_GO_BIT] = busy;
      end else if (stat_hit) begin
         rd_next = DATA_W'(status);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_valid && !req_write;
         rd_data  <= (req_valid && !req_write) ? rd_next : '0;
      end
   end

   // R8, R9: illegal accesses read back as zero
   p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(range_err || size_err)) |-> (rd_data == '0));
   // R3: control bit 0 mirrors busy on a read
   p_ctl_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(cfg_hit && idx == IDX_W'(IDX_CTL))) |-> (rd_data[CTL_GO_BIT] == $past(busy)));
endmodule

// File: tb/sim_texmap_csr_bank.sv
module sim_texmap_csr_bank;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]   req_addr = '0;
   logic [2:0]   req_bytes = 3'd4;
   logic [31:0]  req_wdata = '0;
   logic         rd_valid;
   logic [31:0]  rd_data;
   logic [607:0] cfg_flat;
   logic         busy, eng_start, irq;
   logic         eng_done = 1'b0;

   int n_chk = 0, n_fail = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   texmap_csr_bank u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .cfg_flat(cfg_flat), .busy(busy),
      .eng_start(eng_start), .eng_done(eng_done), .irq(irq));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pop expected read data as results appear
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) check(1, 0, "unexpected read data");
         else check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic access(input logic wr, input int idx, input logic [31:0] d, input logic [2:0] nb);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = 8'(idx * 4);
      req_wdata = d; req_bytes = nb;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_bytes = 3'd4;
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      access(1'b1, idx, d, 3'd4);
   endtask

   task automatic rd(input int idx, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      access(1'b0, idx, 32'h0, 3'd4);
   endtask

   function automatic logic [31:0] pat(input int i);
      logic [7:0] b = 8'(i);
      logic [31:0] p = {b, ~b, 8'h5A, b};
      if (i == 3 || i == 18) p = 32'(i + 40);
      if (i == 5) p = p & ~32'h7;
      if (i == 6) p = p & ~32'h1;
      return p;
   endfunction

   initial begin
      #1_000_000;
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check({29'd0, busy, eng_start, irq}, 32'd0, "R1 outputs after reset");
      check(32'(cfg_flat != '0), 32'd0, "R1 cfg_flat after reset");
      for (int i = 0; i < 20; i++) rd(i, 32'h0, "R1 register zero after reset");

      // R2 fill and read back
      for (int i = 1; i < 19; i++) wr(i, pat(i));
      for (int i = 1; i < 19; i++) rd(i, pat(i), "R2 readback");
      check(cfg_flat[1*32 +: 32], pat(1), "R2 cfg_flat word 1");
      check(cfg_flat[16*32 +: 32], pat(16), "R2 cfg_flat word 16");
      rd(19, 32'h0, "R6 R7 legal values set no flag");

      // R6 range limits
      wr(3, 32'd63);
      rd(19, 32'h0, "R6 brightness 63 legal");
      wr(3, 32'd64);
      wr(18, 32'd100);
      rd(19, 32'h3, "R6 brightness and alpha flags");
      rd(18, 32'd100, "R6 illegal value still stored");
      // R10 write-one-to-clear
      wr(19, 32'h1);
      rd(19, 32'h2, "R10 clear only bit 0");
      wr(19, 32'h3F);
      rd(19, 32'h0, "R10 clear all");

      // R7 alignment
      wr(5, 32'h0000_1008);
      rd(19, 32'h0, "R7 aligned vertex address");
      wr(5, 32'h0000_1004);
      wr(6, 32'h0000_2001);
      rd(19, 32'hC, "R7 misaligned vertex and texture");
      wr(19, 32'h3F);

      // R8 unmapped offset
      wr(25, 32'hFFFF_FFFF);
      rd(25, 32'h0, "R8 unmapped reads zero");
      rd(19, 32'h10, "R8 range flag");
      rd(1, pat(1), "R8 no register touched");
      wr(19, 32'h3F);

      // R9 bad size
      access(1'b1, 1, 32'hDEAD_BEEF, 3'd2);
      rd(1, pat(1), "R9 short write ignored");
      exp_q.push_back(32'h0); tag_q.push_back("R9 short read zero");
      access(1'b0, 1, 32'h0, 3'd1);
      rd(19, 32'h20, "R9 size flag");
      wr(19, 32'h3F);

      // R3 chroma bit and launch
      wr(0, 32'h2);
      rd(0, 32'h2, "R3 chroma bit stored, idle");
      check(32'(eng_start), 32'd0, "R3 no start without go bit");
      wr(0, 32'h3);
      check(32'(eng_start), 32'd1, "R3 start strobe");
      @(negedge clk);
      check(32'(eng_start), 32'd0, "R3 start one cycle");
      rd(0, 32'h3, "R3 busy reads as bit 0");

      // R5 writes while busy
      wr(1, 32'h1234_5678);
      rd(1, pat(1), "R5 config write ignored while busy");
      wr(0, 32'h1);
      check(32'(eng_start), 32'd0, "R5 no retrigger");
      rd(0, 32'h3, "R5 control unchanged while busy");

      // R4 completion
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      check(32'(irq), 32'd1, "R4 irq pulse");
      check(32'(busy), 32'd0, "R4 busy cleared");
      @(negedge clk);
      check(32'(irq), 32'd0, "R4 irq one cycle");
      rd(0, 32'h2, "R4 control bit 0 cleared");
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      check(32'(irq), 32'd0, "R4 done while idle ignored");

      repeat (3) @(negedge clk);
      check(32'(exp_q.size()), 32'd0, "R2 all reads answered");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule